// File: doc/BRIEF.md
# Sync-Paced Dual-Converter Scan Sequencer

This block runs a sixteen-entry conversion list on two converters at once. Converter A owns list entries 0 to 7 and converter B owns entries 8 to 15. Each entry holds three things: a 4-bit input code, a skip bit and a pause bit. A sync pulse starts a scan. The converter then asks an external converter model for one conversion per entry, using a start/done handshake. It stores each returned value in a result slot that belongs to that entry.

When an entry has its pause bit set, the converter stops after converting that entry. It waits for the next sync pulse before it moves on. In this way a single scan can be split into several sync-paced segments. The scan ends at the first skipped entry, or after the lane's last entry. Only then does the sticky end-of-scan flag for that converter rise.

In independent mode each converter is paced by its own sync input. In joint mode converter B takes its sync, skip bits and pause bits from converter A's side, so the two converters step through their entries together.

Top module: `adc_scan_seq`

## Requirements
- R1: A value returned for lane A's k-th conversion is stored in result slot k. A value returned for lane B's k-th conversion is stored in slot 8+k. Slot s occupies bits [12s+11:12s] of `result_o`.
- R2: While `conv_start_o[l]` is high, `conv_chan_o[4l+3:4l]` carries the code of the current entry. Entry s takes its code from `list_i[4s+3:4s]`.
- R3: An idle converter starts a scan on a sync pulse only when its first entry's skip bit is clear. If that bit is set, the pulse leaves the converter idle.
- R4: A scan ends after the lane's last entry, or earlier when the next entry's bit in `skip_i` is set. No further conversion is requested after that.
- R5: After converting an entry whose `pause_i` bit is set, the converter raises `halted_o`. It requests nothing more until a sync pulse arrives. That pulse clears `halted_o` and requests the next entry.
- R6: After converting an entry whose pause bit is clear, the converter requests the next entry in the very next cycle, without waiting for sync.
- R7: A sync pulse that arrives while a conversion is being requested or is in progress is ignored.
- R8: `eos_o[l]` rises on the same edge that a scan ends, and never at a pause. It stays set until a one-cycle pulse on `eos_clr_i[l]` clears it; a scan end in the same cycle wins. `irq_o[l]` equals `eos_o[l] & irq_en_i[l]`.
- R9: A lane's valid bits in `valid_o` all clear when its scan starts. Each bit sets when its slot is written.
- R10: With `joint_i` high, converter B starts and resumes on `sync_a_i`, ignores `sync_b_i`, and uses skip and pause bits 0 to 7. With `joint_i` low it uses `sync_b_i` and bits 8 to 15.
- R11: After reset no conversion is requested, and every flag, halt output and valid bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| joint_i | input | 1 | 1 = both converters paced by the A side |
| sync_a_i | input | 1 | Sync pulse for converter A |
| sync_b_i | input | 1 | Sync pulse for converter B |
| list_i | input | 64 | Sixteen 4-bit entry codes, entry 0 in the lowest nibble |
| skip_i | input | 16 | One skip bit per entry |
| pause_i | input | 16 | One pause bit per entry |
| irq_en_i | input | 2 | Interrupt enable per converter |
| eos_clr_i | input | 2 | Write-one-to-clear pulse for the end-of-scan flags |
| conv_start_o | output | 2 | Conversion request per converter |
| conv_chan_o | output | 8 | Code of the requested entry, 4 bits per converter |
| conv_done_i | input | 2 | Conversion complete per converter |
| conv_data_i | input | 24 | Conversion value, 12 bits per converter |
| halted_o | output | 2 | Converter waiting at a pause |
| eos_o | output | 2 | Sticky end-of-scan flags |
| irq_o | output | 2 | Enabled end-of-scan interrupts |
| result_o | output | 192 | Sixteen 12-bit result slots |
| valid_o | output | 16 | Valid bit per result slot |

## Verification
The assertions rely on a few properties of the inputs:
- `conv_done_i` pulses once per request, and only after that request has been accepted.
- The skip and pause words stay steady while a scan is running.
- `joint_i` changes only while both converters are idle.
- In joint mode, both converters report done after the same latency.

The lockstep check depends on these conditions holding. The stimulus respects all of them. The bench's converter model answers every request after a fixed three-cycle delay. Configuration words and the mode are changed only after both lanes have finished their scans.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2,
        ST_HALT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/adc_eos_flag.sv
module adc_eos_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;

    a_r8_set_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/adc_scan_lane.sv
module adc_scan_lane
    import adc_seq_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int CODE_W = 4,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_i,
    input  logic [SLOTS*CODE_W-1:0]  codes_i,
    input  logic [SLOTS-1:0]         skip_i,
    input  logic [SLOTS-1:0]         pause_i,
    input  logic                     conv_done_i,
    input  logic [DATA_W-1:0]        conv_data_i,
    output logic                     conv_start_o,
    output logic [CODE_W-1:0]        conv_chan_o,
    output logic                     halted_o,
    output logic                     scan_end_o,
    output logic [SLOTS*DATA_W-1:0]  res_o,
    output logic [SLOTS-1:0]         valid_o
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        seq_state_e               st;
        logic [IDX_W-1:0]         idx;
        logic [SLOTS-1:0]         vld;
        logic [SLOTS*DATA_W-1:0]  res;
    } lane_t;

    lane_t            s_d, s_q;
    logic [IDX_W-1:0] idx_nxt;
    logic             last_slot;

    always_comb begin
        idx_nxt   = s_q.idx + 1'b1;
        last_slot = (s_q.idx == LAST_IDX) || skip_i[idx_nxt];
        s_d       = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (sync_i && !skip_i[0]) begin
                    s_d.st  = ST_REQ;
                    s_d.idx = '0;
                    s_d.vld = '0;
                end
            end
            ST_REQ: s_d.st = ST_BUSY;
            ST_BUSY: begin
                if (conv_done_i) begin
                    s_d.res[s_q.idx*DATA_W +: DATA_W] = conv_data_i;
                    s_d.vld[s_q.idx]                  = 1'b1;
                    if (last_slot) begin
                        s_d.st = ST_IDLE;
                    end else if (pause_i[s_q.idx]) begin
                        s_d.st = ST_HALT;
                    end else begin
                        s_d.st  = ST_REQ;
                        s_d.idx = idx_nxt;
                    end
                end
            end
            ST_HALT: begin
                if (sync_i) begin
                    s_d.st  = ST_REQ;
                    s_d.idx = idx_nxt;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start_o = (s_q.st == ST_REQ);
    assign conv_chan_o  = codes_i[s_q.idx*CODE_W +: CODE_W];
    assign halted_o     = (s_q.st == ST_HALT);
    assign scan_end_o   = (s_q.st == ST_BUSY) && conv_done_i && last_slot;
    assign res_o        = s_q.res;
    assign valid_o      = s_q.vld;

    a_r6_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BUSY && conv_done_i && !last_slot && !pause_i[s_q.idx])
        |=> conv_start_o);
    a_r5_halt_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BUSY && conv_done_i && !last_slot && pause_i[s_q.idx])
        |=> halted_o);
    a_r5_wait_for_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !sync_i) |=> (halted_o && !conv_start_o));
    a_r7_busy_ignores_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BUSY && !conv_done_i) |=> !conv_start_o);
    a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && sync_i && !skip_i[0]) |=> (valid_o == '0));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int LANE_SLOTS = 8,
    parameter int CODE_W     = 4,
    parameter int DATA_W     = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                joint_i,
    input  logic                                sync_a_i,
    input  logic                                sync_b_i,
    input  logic [2*LANE_SLOTS*CODE_W-1:0]      list_i,
    input  logic [2*LANE_SLOTS-1:0]             skip_i,
    input  logic [2*LANE_SLOTS-1:0]             pause_i,
    input  logic [1:0]                          irq_en_i,
    input  logic [1:0]                          eos_clr_i,
    output logic [1:0]                          conv_start_o,
    output logic [2*CODE_W-1:0]                 conv_chan_o,
    input  logic [1:0]                          conv_done_i,
    input  logic [2*DATA_W-1:0]                 conv_data_i,
    output logic [1:0]                          halted_o,
    output logic [1:0]                          eos_o,
    output logic [1:0]                          irq_o,
    output logic [2*LANE_SLOTS*DATA_W-1:0]      result_o,
    output logic [2*LANE_SLOTS-1:0]             valid_o
);
    localparam int LIST_W = LANE_SLOTS * CODE_W;
    localparam int RES_W  = LANE_SLOTS * DATA_W;

    logic [NUM_LANES-1:0] scan_end;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic                  sync_sel;
        logic [LANE_SLOTS-1:0] skip_sel;
        logic [LANE_SLOTS-1:0] pause_sel;

        if (l == 0) begin : g_pace_a
            assign sync_sel  = sync_a_i;
            assign skip_sel  = skip_i[0 +: LANE_SLOTS];
            assign pause_sel = pause_i[0 +: LANE_SLOTS];
        end else begin : g_pace_sel
            assign sync_sel  = joint_i ? sync_a_i : sync_b_i;
            assign skip_sel  = joint_i ? skip_i[0 +: LANE_SLOTS]
                                       : skip_i[l*LANE_SLOTS +: LANE_SLOTS];
            assign pause_sel = joint_i ? pause_i[0 +: LANE_SLOTS]
                                       : pause_i[l*LANE_SLOTS +: LANE_SLOTS];
        end

        adc_scan_lane #(
            .SLOTS  (LANE_SLOTS),
            .CODE_W (CODE_W),
            .DATA_W (DATA_W)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .sync_i       (sync_sel),
            .codes_i      (list_i[l*LIST_W +: LIST_W]),
            .skip_i       (skip_sel),
            .pause_i      (pause_sel),
            .conv_done_i  (conv_done_i[l]),
            .conv_data_i  (conv_data_i[l*DATA_W +: DATA_W]),
            .conv_start_o (conv_start_o[l]),
            .conv_chan_o  (conv_chan_o[l*CODE_W +: CODE_W]),
            .halted_o     (halted_o[l]),
            .scan_end_o   (scan_end[l]),
            .res_o        (result_o[l*RES_W +: RES_W]),
            .valid_o      (valid_o[l*LANE_SLOTS +: LANE_SLOTS])
        );

        adc_eos_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (scan_end[l]),
            .clr_i  (eos_clr_i[l]),
            .en_i   (irq_en_i[l]),
            .flag_o (eos_o[l]),
            .irq_o  (irq_o[l])
        );
    end

    a_r10_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (joint_i && conv_start_o[0]) |-> conv_start_o[1]);
    a_r10_joint_no_b_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (joint_i && conv_start_o[1]) |-> conv_start_o[0]);
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         joint = 1'b0;
    logic         sync_a = 1'b0;
    logic         sync_b = 1'b0;
    logic [63:0]  list = '0;
    logic [15:0]  skip = '0;
    logic [15:0]  pause = '0;
    logic [1:0]   irq_en = '0;
    logic [1:0]   eos_clr = '0;
    logic [1:0]   conv_start;
    logic [7:0]   conv_chan;
    logic [1:0]   conv_done = '0;
    logic [23:0]  conv_data = '0;
    logic [1:0]   halted;
    logic [1:0]   eos;
    logic [1:0]   irq;
    logic [191:0] result;
    logic [15:0]  valid;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    adc_scan_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .joint_i      (joint),
        .sync_a_i     (sync_a),
        .sync_b_i     (sync_b),
        .list_i       (list),
        .skip_i       (skip),
        .pause_i      (pause),
        .irq_en_i     (irq_en),
        .eos_clr_i    (eos_clr),
        .conv_start_o (conv_start),
        .conv_chan_o  (conv_chan),
        .conv_done_i  (conv_done),
        .conv_data_i  (conv_data),
        .halted_o     (halted),
        .eos_o        (eos),
        .irq_o        (irq),
        .result_o     (result),
        .valid_o      (valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // converter model: answers each request after LAT cycles with the code
    int        cnt [2];
    logic [3:0] held [2];
    int        n_start [2];
    initial begin
        cnt[0] = 0; cnt[1] = 0; n_start[0] = 0; n_start[1] = 0;
        held[0] = '0; held[1] = '0;
        forever begin
            @(negedge clk);
            for (int l = 0; l < 2; l++) begin
                conv_done[l] = 1'b0;
                if (cnt[l] > 0) begin
                    cnt[l]--;
                    if (cnt[l] == 0) begin
                        conv_done[l] = 1'b1;
                        conv_data[l*12 +: 12] = {8'd0, held[l]};
                    end
                end
                if (rst_n && conv_start[l]) begin
                    cnt[l] = LAT;
                    held[l] = conv_chan[l*4 +: 4];
                    n_start[l]++;
                end
            end
        end
    end

    // behavioural reference, updated on every rising edge from the inputs
    int         mst [2];
    int         midx [2];
    bit         meos [2];
    logic [11:0] exp_res [16];
    bit         exp_val [16];
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                for (int l = 0; l < 2; l++) begin
                    mst[l] = 0; midx[l] = 0; meos[l] = 0;
                end
                for (int k = 0; k < 16; k++) begin
                    exp_res[k] = '0; exp_val[k] = 0;
                end
            end else begin
                for (int l = 0; l < 2; l++) begin
                    bit s;
                    bit fin;
                    int pb;
                    int db;
                    s   = (l == 0 || joint) ? sync_a : sync_b;
                    pb  = (l == 1 && !joint) ? 8 : 0;
                    db  = l * 8;
                    fin = 0;
                    case (mst[l])
                        0: if (s && !skip[pb]) begin
                            mst[l] = 1; midx[l] = 0;
                            for (int k = 0; k < 8; k++) exp_val[db+k] = 0;
                        end
                        1: mst[l] = 2;
                        2: if (conv_done[l]) begin
                            exp_res[db+midx[l]] = conv_data[l*12 +: 12];
                            exp_val[db+midx[l]] = 1;
                            if (midx[l] == 7 || skip[pb+midx[l]+1]) begin
                                mst[l] = 0; fin = 1;
                            end else if (pause[pb+midx[l]]) begin
                                mst[l] = 3;
                            end else begin
                                midx[l]++; mst[l] = 1;
                            end
                        end
                        default: if (s) begin
                            midx[l]++; mst[l] = 1;
                        end
                    endcase
                    meos[l] = fin ? 1'b1 : (eos_clr[l] ? 1'b0 : meos[l]);
                end
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int l = 0; l < 2; l++) begin
                    chk(conv_start[l] == (mst[l] == 1), "R6", "conv_start",
                        conv_start[l], mst[l] == 1);
                    chk(halted[l] == (mst[l] == 3), "R5", "halted",
                        halted[l], mst[l] == 3);
                    chk(eos[l] == meos[l], "R8", "eos", eos[l], meos[l]);
                    chk(irq[l] == (meos[l] & irq_en[l]), "R8", "irq",
                        irq[l], meos[l] & irq_en[l]);
                    if (mst[l] == 1)
                        chk(conv_chan[l*4 +: 4] == list[(l*8+midx[l])*4 +: 4],
                            "R2", "conv_chan", conv_chan[l*4 +: 4],
                            list[(l*8+midx[l])*4 +: 4]);
                end
                for (int k = 0; k < 16; k++) begin
                    chk(valid[k] == exp_val[k], "R9", "valid bit", valid[k], exp_val[k]);
                    if (exp_val[k])
                        chk(result[k*12 +: 12] == exp_res[k], "R1", "result slot",
                            result[k*12 +: 12], exp_res[k]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_a();
        sync_a = 1'b1; step(1); sync_a = 1'b0;
    endtask

    task automatic pulse_b();
        sync_b = 1'b1; step(1); sync_b = 1'b0;
    endtask

    initial begin
        int sa;
        int sb;
        step(4);
        rst_n = 1'b1;
        step(1);
        // R11 reset state
        chk(conv_start == 2'b00, "R11", "start after reset", conv_start, 0);
        chk(halted == 2'b00, "R11", "halted after reset", halted, 0);
        chk(eos == 2'b00, "R11", "eos after reset", eos, 0);
        chk(valid == 16'h0, "R11", "valid after reset", valid, 0);

        for (int s = 0; s < 8; s++) list[s*4 +: 4] = 4'(s + 1);
        list[32 +: 16] = 16'h8888;
        list[48 +: 16] = 16'h00EA;
        skip   = 16'hC010;
        pause  = 16'h0702;
        irq_en = 2'b11;

        // independent mode, lane B in four segments
        pulse_b();
        step(2);
        pulse_b();               // lands during a conversion
        step(10);
        chk(n_start[1] == 1, "R7", "sync during conversion ignored", n_start[1], 1);
        chk(halted[1] == 1'b1, "R5", "B halted after paused entry", halted[1], 1);
        chk(eos[1] == 1'b0, "R8", "no eos at a pause", eos[1], 0);
        pulse_b(); step(10);
        pulse_b(); step(10);
        chk(n_start[1] == 3, "R5", "one entry per sync while paused", n_start[1], 3);
        pulse_b(); step(20);
        chk(n_start[1] == 6, "R4", "B stops at first skipped entry", n_start[1], 6);
        chk(eos[1] == 1'b1, "R8", "eos after final segment", eos[1], 1);
        chk(result[13*12 +: 12] == 12'h00E, "R1", "slot 13 value",
            result[13*12 +: 12], 12'h00E);
        chk(halted[1] == 1'b0, "R6", "last segment ran without pause", halted[1], 0);

        // lane A: pause after entry 1, skip at entry 4
        pulse_a(); step(12);
        chk(n_start[0] == 2, "R5", "A paused after entry 1", n_start[0], 2);
        pulse_a(); step(20);
        chk(n_start[0] == 4, "R4", "A ended before skipped entry", n_start[0], 4);
        chk(n_start[1] == 6, "R10", "B not paced by A in independent mode", n_start[1], 6);

        // write-one-to-clear and interrupt enable
        eos_clr = 2'b01; step(1); eos_clr = 2'b00; step(1);
        chk(eos == 2'b10, "R8", "w1c clears only lane A", eos, 2'b10);
        irq_en = 2'b00; step(1);
        chk(irq == 2'b00, "R8", "irq masked", irq, 0);

        // first entry skipped: sync leaves the lane idle
        skip = 16'hC011;
        sa = n_start[0];
        pulse_a(); step(10);
        chk(n_start[0] == sa, "R3", "scan not started on skipped entry 0", n_start[0], sa);
        chk(valid[3:0] == 4'hF, "R3", "previous results kept", valid[3:0], 4'hF);

        // joint mode: B follows A pacing, ignores its own bits and sync
        joint = 1'b1;
        skip  = 16'hC000;
        pause = 16'h0008;
        irq_en = 2'b11;
        step(1);
        sa = n_start[0];
        sb = n_start[1];
        pulse_b(); step(6);
        chk(n_start[1] == sb, "R10", "sync_b ignored in joint mode", n_start[1], sb);
        pulse_a(); step(20);
        chk(n_start[0] - sa == 4, "R10", "A segment in joint mode", n_start[0] - sa, 4);
        chk(n_start[1] - sb == 4, "R10", "B paced with A", n_start[1] - sb, 4);
        chk(halted == 2'b11, "R10", "both halted together", halted, 2'b11);
        pulse_a(); step(30);
        chk(n_start[1] - sb == 8, "R10", "B uses A skip bits", n_start[1] - sb, 8);
        chk(valid == 16'hFFFF, "R9", "all slots valid", valid, 16'hFFFF);
        chk(eos == 2'b11, "R8", "both flags set", eos, 2'b11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule